// File: doc/BRIEF.md
# Triple-Copy Memory Scrubber with Majority Write-Back

This block keeps a small on-chip memory as three identical dual-port RAM copies and repairs upsets in the background. The user side drives the first port of every copy. A write lands in the copies chosen by a three-bit copy mask, which is normally all ones. A read returns the bitwise two-of-three majority of the three copies, one cycle after the request.

The second port of every copy belongs to the scrubber. A triplicated, self-voting address counter walks that port across the whole memory. Each location takes three cycles: read, vote, and a write-back cycle. In the write-back cycle the majority word is written into all three copies, but only if some copy disagreed. Each repair raises a one-cycle pulse with a code naming the faulty copy, and it bumps a saturating repair counter. An address comparator drops a repair when the user writes the same location during that location's three-cycle pass, because the voted word may then be stale. The counter still moves on, and the location is repaired on the next sweep.

Top module: `tmr_ram_scrubber`

## Requirements
- R1: Synchronously with an active-low reset, the repair counter clears to 0, the repair pulse and sweep pulse are low, and the scrub address is 0.
- R2: A user write with copy mask 3'b111 stores the word in all three copies. A user read returns the stored word on `usr_rdata` on the clock edge after the request.
- R3: A user read returns the bitwise majority of the three copies, so a word corrupted in any single copy still reads back correctly.
- R4: When exactly one copy disagrees with the majority at the scrubbed location, the majority word is written back into all copies and `corr_valid` pulses once. `corr_copy` then holds the faulty copy's index (0, 1 or 2).
- R5: When disagreeing bits are spread over more than one copy at the same location, the location is still repaired and `corr_copy` reads 3.
- R6: `corr_count` rises by one per repair and holds at its all-ones maximum.
- R7: Each location takes exactly three cycles. The address runs from 0 to DEPTH-1 and wraps to 0. `sweep_done` pulses when the address returns to 0, once every 3*DEPTH cycles.
- R8: If the user writes the scrubbed location during any of its three cycles, no repair write or pulse occurs for that pass, the user data is kept, and the address still advances.
- R9: A memory whose copies all agree produces no repairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_en | input | 1 | User port access request |
| usr_we | input | 1 | User write (1) or read (0) |
| usr_wr_mask | input | 3 | Copies written by a user write, bit i = copy i |
| usr_addr | input | AW | User word address |
| usr_wdata | input | WIDTH | User write data |
| usr_rdata | output | WIDTH | Majority-voted read data, one cycle after request |
| scrub_addr | output | AW | Location currently being scrubbed |
| corr_valid | output | 1 | One-cycle pulse after a repair write |
| corr_copy | output | 2 | Faulty copy index, or 3 when several copies differ |
| corr_count | output | CNT_W | Saturating repair counter |
| sweep_done | output | 1 | Pulse when the scrub address wraps to 0 |

## Verification
The bench fills every word with an arithmetic pattern and reads all of it back. It then runs clean sweeps and checks that they cause no repairs and that the sweep pulses are spaced 3*DEPTH cycles apart. Next it corrupts a single copy at a time, for each of the three copies, which separates the per-copy index code from a generic repair. A mixed fault that spreads bits over two copies must yield code 3.

A further run of faults pushes the small counter past its maximum. Finally, a user write held on the location under scrub tells a dropped repair apart from a stale write-back: the user's value must survive, and the leftover fault must be fixed one sweep later.

// File: rtl/scrub_pkg.sv
// Package: shared types and helpers for the triple-copy memory scrubber.
// Assumes: all copies share one clock.
package scrub_pkg;

    // Per-location scrub phase; each location spends one cycle in each.
    typedef enum logic [1:0] {
        PH_READ  = 2'd0,
        PH_VOTE  = 2'd1,
        PH_WRITE = 2'd2
    } scrub_phase_t;

    // Code reported when more than one copy holds differing bits.
    localparam logic [1:0] MULTI_COPY = 2'd3;

endpackage

// File: rtl/scrub_ram_copy.sv
// Module: one dual-port RAM copy. Port A serves the user, port B the scrubber.
// Assumes: one-cycle registered read on both ports, read-before-write when
// the same port reads and writes. The two ports never write one address in
// the same cycle; the scrubber's comparator guarantees this.
module scrub_ram_copy #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,
    input  logic             a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_en,
    input  logic             b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage array writes from both ports.
    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_addr] <= a_wdata;
        if (b_en && b_we) mem[b_addr] <= b_wdata;
    end

    // Port A registered read.
    always_ff @(posedge clk) begin
        if (!rst_n)            a_rdata <= '0;
        else if (a_en && !a_we) a_rdata <= mem[a_addr];
    end

    // Port B registered read.
    always_ff @(posedge clk) begin
        if (!rst_n)            b_rdata <= '0;
        else if (b_en && !b_we) b_rdata <= mem[b_addr];
    end

    AST_PORTS_NO_SAME_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we) |-> (a_addr != b_addr)); // R8

endmodule

// File: rtl/scrub_voter.sv
// Module: bitwise two-of-three voter with fault localisation.
// Assumes: purely combinational; bad_copy is only meaningful with mismatch.
module scrub_voter #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] c0,
    input  logic [WIDTH-1:0] c1,
    input  logic [WIDTH-1:0] c2,
    output logic [WIDTH-1:0] voted,
    output logic             mismatch,
    output logic [1:0]       bad_copy
);
    import scrub_pkg::*;

    logic [2:0] differs;

    // Majority word and per-copy disagreement flags.
    always_comb begin
        voted      = (c0 & c1) | (c1 & c2) | (c0 & c2);
        differs[0] = |(c0 ^ voted);
        differs[1] = |(c1 ^ voted);
        differs[2] = |(c2 ^ voted);
        mismatch   = |differs;
    end

    // Name the single faulty copy, or report several.
    always_comb begin
        unique case (differs)
            3'b001:  bad_copy = 2'd0;
            3'b010:  bad_copy = 2'd1;
            3'b100:  bad_copy = 2'd2;
            default: bad_copy = MULTI_COPY;
        endcase
    end

endmodule

// File: rtl/scrub_addr_ctr.sv
// Module: triplicated scrub address counter, each copy reloaded from the
// majority of all three, wrapping at DEPTH-1.
// Assumes: advance is a single-cycle strobe.
module scrub_addr_ctr #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    output logic [AW-1:0] addr,
    output logic          wrap
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ctr [3];
    logic [AW-1:0] next_addr;

    // Majority of the three copies and the shared next value.
    always_comb begin
        addr      = (ctr[0] & ctr[1]) | (ctr[1] & ctr[2]) | (ctr[0] & ctr[2]);
        wrap      = advance && (addr == LAST);
        next_addr = (addr == LAST) ? '0 : addr + AW'(1);
    end

    for (genvar i = 0; i < 3; i++) begin : g_copy
        // One counter copy, rebuilt from the vote on every step.
        always_ff @(posedge clk) begin
            if (!rst_n)       ctr[i] <= '0;
            else if (advance) ctr[i] <= next_addr;
            else              ctr[i] <= addr;
        end
    end

    AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr[0] == ctr[1]) && (ctr[1] == ctr[2])); // R7
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST); // R7

endmodule

// File: rtl/tmr_ram_scrubber.sv
// Module: top of the triple-copy memory scrubber. Holds three RAM copies,
// a voted user read path, and a read/vote/write-back scrub sequencer.
// Assumes: a single clock, synchronous active-low reset, DEPTH >= 2.
module tmr_ram_scrubber #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 256,
    parameter int CNT_W = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usr_en,
    input  logic             usr_we,
    input  logic [2:0]       usr_wr_mask,
    input  logic [AW-1:0]    usr_addr,
    input  logic [WIDTH-1:0] usr_wdata,
    output logic [WIDTH-1:0] usr_rdata,
    output logic [AW-1:0]    scrub_addr,
    output logic             corr_valid,
    output logic [1:0]       corr_copy,
    output logic [CNT_W-1:0] corr_count,
    output logic             sweep_done
);
    import scrub_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    scrub_phase_t     phase;
    logic [WIDTH-1:0] a_rd [3];
    logic [WIDTH-1:0] b_rd [3];
    logic [WIDTH-1:0] b_voted, vote_q;
    logic             b_mism, mism_q;
    logic [1:0]       b_bad, bad_q;
    logic             taint_q;
    logic             clash;
    logic             b_en, b_we, do_wb;
    logic             advance, wrap;
    logic             a_mism_unused;
    logic [1:0]       a_bad_unused;

    // Comparator: user write to the location under scrub.
    always_comb clash = usr_en && usr_we && (usr_addr == scrub_addr);

    // Port B control for the current phase.
    always_comb begin
        do_wb   = (phase == PH_WRITE) && mism_q && !taint_q && !clash;
        b_en    = (phase == PH_READ) || do_wb;
        b_we    = do_wb;
        advance = (phase == PH_WRITE);
    end

    for (genvar i = 0; i < 3; i++) begin : g_ram
        scrub_ram_copy #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_copy (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_en    (usr_en && (!usr_we || usr_wr_mask[i])),
            .a_we    (usr_we),
            .a_addr  (usr_addr),
            .a_wdata (usr_wdata),
            .a_rdata (a_rd[i]),
            .b_en    (b_en),
            .b_we    (b_we),
            .b_addr  (scrub_addr),
            .b_wdata (vote_q),
            .b_rdata (b_rd[i])
        );
    end

    scrub_voter #(.WIDTH(WIDTH)) i_usr_vote (
        .c0 (a_rd[0]), .c1 (a_rd[1]), .c2 (a_rd[2]),
        .voted (usr_rdata), .mismatch (a_mism_unused), .bad_copy (a_bad_unused)
    );

    scrub_voter #(.WIDTH(WIDTH)) i_scrub_vote (
        .c0 (b_rd[0]), .c1 (b_rd[1]), .c2 (b_rd[2]),
        .voted (b_voted), .mismatch (b_mism), .bad_copy (b_bad)
    );

    scrub_addr_ctr #(.DEPTH(DEPTH)) i_addr (
        .clk (clk), .rst_n (rst_n), .advance (advance),
        .addr (scrub_addr), .wrap (wrap)
    );

    // Phase sequencer: read, vote, write-back, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_READ;
        else begin
            unique case (phase)
                PH_READ:  phase <= PH_VOTE;
                PH_VOTE:  phase <= PH_WRITE;
                default:  phase <= PH_READ;
            endcase
        end
    end

    // Capture the vote result and track user writes during the pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_q  <= '0;
            mism_q  <= 1'b0;
            bad_q   <= 2'd0;
            taint_q <= 1'b0;
        end else begin
            if (phase == PH_VOTE) begin
                vote_q <= b_voted;
                mism_q <= b_mism;
                bad_q  <= b_bad;
            end
            if (phase == PH_READ) taint_q <= clash;
            else                  taint_q <= taint_q || clash;
        end
    end

    // Repair reporting and sweep pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_valid <= 1'b0;
            corr_copy  <= 2'd0;
            corr_count <= '0;
            sweep_done <= 1'b0;
        end else begin
            corr_valid <= do_wb;
            sweep_done <= wrap;
            if (do_wb) begin
                corr_copy <= bad_q;
                if (corr_count != CNT_MAX) corr_count <= corr_count + CNT_W'(1);
            end
        end
    end

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        corr_count >= $past(corr_count)); // R6
    AST_CNT_HOLD_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_count == CNT_MAX) |=> (corr_count == CNT_MAX)); // R6
    AST_PULSE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> ($past(phase) == PH_WRITE)); // R4
    AST_NO_PULSE_AFTER_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && clash) |=> !corr_valid); // R8
    AST_DONE_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (scrub_addr == '0)); // R7
    AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> $stable(scrub_addr)); // R7

endmodule

// File: tb/test_tmr_ram_scrubber.sv
module test_tmr_ram_scrubber;
    localparam int W  = 8;
    localparam int D  = 16;
    localparam int CW = 2;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usr_en = 1'b0, usr_we = 1'b0;
    logic [2:0]    usr_wr_mask = 3'b111;
    logic [AW-1:0] usr_addr = '0;
    logic [W-1:0]  usr_wdata = '0;
    logic [W-1:0]  usr_rdata;
    logic [AW-1:0] scrub_addr;
    logic          corr_valid, sweep_done;
    logic [1:0]    corr_copy;
    logic [CW-1:0] corr_count;

    int tests = 0, fails = 0;
    int cyc = 0, pulses = 0, last_code = -1;
    int done_cyc [$];

    tmr_ram_scrubber #(.WIDTH(W), .DEPTH(D), .CNT_W(CW)) i_tmr_ram_scrubber (
        .clk, .rst_n, .usr_en, .usr_we, .usr_wr_mask, .usr_addr, .usr_wdata,
        .usr_rdata, .scrub_addr, .corr_valid, .corr_copy, .corr_count, .sweep_done
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && corr_valid) begin pulses++; last_code = int'(corr_copy); end
        if (rst_n && sweep_done) done_cyc.push_back(cyc);
    end

    function automatic logic [W-1:0] pat(int i);
        return W'(i * 37 + 5);
    endfunction

    function automatic int sat(int v);
        return (v > 3) ? 3 : v;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [W-1:0] v, logic [2:0] m);
        @(negedge clk);
        usr_en = 1; usr_we = 1; usr_addr = AW'(a); usr_wdata = v; usr_wr_mask = m;
        @(negedge clk);
        usr_en = 0; usr_we = 0; usr_wr_mask = 3'b111;
    endtask

    task automatic rd(int a, output logic [W-1:0] v);
        @(negedge clk);
        usr_en = 1; usr_we = 0; usr_addr = AW'(a);
        @(negedge clk);
        v = usr_rdata;
        usr_en = 0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!sweep_done);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++; tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [W-1:0] v;
        int base, p0, n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 count", int'(corr_count), 0);
        check("R1 valid", int'(corr_valid), 0);
        check("R1 addr", int'(scrub_addr), 0);
        @(negedge clk); rst_n = 1;

        // R2: fill and read back
        for (int i = 0; i < D; i++) wr(i, pat(i), 3'b111);
        for (int i = 0; i < D; i++) begin rd(i, v); check("R2 readback", int'(v), int'(pat(i))); end

        // R9 and R7: clean sweeps
        wait_done(); wait_done();
        p0 = pulses; n = done_cyc.size();
        wait_done(); wait_done();
        check("R9 no repair on clean memory", pulses - p0, 0);
        check("R7 sweep period", done_cyc[done_cyc.size()-1] - done_cyc[done_cyc.size()-2], 3 * D);
        check("R7 pulses per two sweeps", done_cyc.size() - n, 2);

        // R3/R4: single-copy faults in each copy
        for (int k = 0; k < 3; k++) begin
            base = int'(corr_count); p0 = pulses;
            wait_done();
            wr(3 + k, ~pat(3 + k), 3'(1 << k));
            rd(3 + k, v);
            check("R3 voted read masks fault", int'(v), int'(pat(3 + k)));
            wait_done(); wait_done();
            check("R4 one repair", pulses - p0, 1);
            check("R4 faulty copy code", last_code, k);
            check("R6 count step", int'(corr_count), sat(base + 1));
            // second fault in another copy proves the first was repaired
            wr(3 + k, pat(3 + k) ^ 8'h0F, 3'(1 << ((k + 1) % 3)));
            rd(3 + k, v);
            check("R4 copies agree after repair", int'(v), int'(pat(3 + k)));
            wait_done(); wait_done();
        end

        // R5: bits spread over two copies
        p0 = pulses;
        wait_done();
        wr(9, pat(9) ^ 8'h01, 3'b001);
        wr(9, pat(9) ^ 8'h02, 3'b010);
        wait_done(); wait_done();
        check("R5 one repair", pulses - p0, 1);
        check("R5 multi-copy code", last_code, 3);
        rd(9, v);
        check("R5 repaired value", int'(v), int'(pat(9)));

        // R6: saturation at all-ones
        check("R6 saturated", int'(corr_count), 3);

        // R8: user write during scrub of the same location
        wait_done();
        wr(12, 8'hAA, 3'b001);
        while (scrub_addr != AW'(12)) @(negedge clk);
        p0 = pulses;
        usr_en = 1; usr_we = 1; usr_addr = AW'(12); usr_wdata = 8'h55; usr_wr_mask = 3'b110;
        while (scrub_addr == AW'(12)) @(negedge clk);
        usr_en = 0; usr_we = 0; usr_wr_mask = 3'b111;
        repeat (2) @(negedge clk);
        check("R8 repair dropped", pulses - p0, 0);
        check("R8 address advanced", int'(scrub_addr), 13);
        rd(12, v);
        check("R8 user data kept", int'(v), 8'h55);
        wait_done(); wait_done();
        check("R8 repaired next sweep", pulses - p0, 1);
        check("R8 code of leftover fault", last_code, 0);
        rd(12, v);
        check("R8 final value", int'(v), 8'h55);

        // R9: everything clean again
        p0 = pulses;
        wait_done(); wait_done();
        check("R9 no further repairs", pulses - p0, 0);
        finish_run();
    end
endmodule